// File: doc/BRIEF.md
# Emulated Last-Level Cache Tag Unit with Miss Latency Injection

This block pretends that an additional cache level sits underneath the processors' private caches. It keeps no data. Every line that the emulated level would hold is represented only by a tag and a valid bit in a direct-mapped array. The real main memory always supplies the data. The block's only effect on the system is time. When a snooped read misses the emulated tags, the block asks the bus tracker to stall the snoop phase for a programmable number of cycles. A snooped read that hits passes through untouched.

Because of this, the unmodified memory latency becomes the emulated hit latency. The miss latency is the injected stall time added to the memory latency. Each snooped transaction installs its line, and writes allocate without ever stalling. Saturating counters of accesses, hits and misses, together with the stall length, sit behind a small register port so that a host can collect them.

The emulated capacity is a parameter from 1 MB to 64 MB (as a power of two). The line size is a parameter from 32 B to 512 B. The index and tag widths are derived from these two parameters.

Top module: `llc_tag_emu`

## Requirements
- R1: After reset every valid bit is clear, all three counters read 0, the stall-length register reads STALL_INIT (default 4), and stall_req is low.
- R2: A snooped address splits into a line offset in bits [LINE_LOG2-1:0], a set index in bits [CAP_LOG2-1:LINE_LOG2] and a tag in bits [ADDR_W-1:CAP_LOG2] (defaults: index = addr[19:9], tag = addr[31:20]). Each set holds one tag, so a second tag in the same set evicts the first.
- R3: A snooped read (snp_write=0) that misses, with a stall length N>0, drives stall_req high for exactly N consecutive cycles, starting in the cycle after the request. The line is then installed.
- R4: A snooped read that hits the tag array causes no stall cycle.
- R5: A snooped write (snp_write=1) installs its line exactly as a read would, and it never raises stall_req, whether it hits or misses.
- R6: A stall length of 0 suppresses all stalls. Lookups, installs and counters continue unchanged.
- R7: Each snooped transaction (read or write) adds one to the access counter, and adds one to either the hit counter or the miss counter according to the lookup outcome.
- R8: Each counter is CNT_W bits wide (32 by default) and stops at its all-ones value instead of wrapping.
- R9: Register map on reg_addr: 0 = stall length (read/write, low STALL_W bits), 1 = accesses, 2 = hits, 3 = misses (read-only). Offsets 4 to 7 read as 0, and writes to any offset other than 0 change nothing.
- R10: A read miss that arrives while a stall is still running restarts the stall, so stall_req stays high for N further cycles counted from that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | A snooped transaction is presented this cycle |
| snp_write | input | 1 | 1 = write transaction, 0 = read transaction |
| snp_addr | input | ADDR_W | Physical address of the snooped transaction |
| stall_req | output | 1 | Request to the bus tracker to stall the snoop phase |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |

## Verification
Random traffic is limited to eight sets and four tags, so the bench sees a dense mix of hits, cold misses and conflict evictions. A model of the tag array predicts the stall length of each transaction. Directed accesses separate a same-line hit from a same-set conflict and from a different-set neighbour. Other directed cases exercise write-allocate, a zero stall length and a miss that arrives during a running stall. A long burst with stalls disabled drives every counter into saturation. This shows whether the counters stop or wrap, and whether hits and misses stay apart.

// File: rtl/llc_emu_pkg.sv
package llc_emu_pkg;

   localparam int REG_DW = 32;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      OFS_STALL_LEN = 3'd0,
      OFS_ACCESSES  = 3'd1,
      OFS_HITS      = 3'd2,
      OFS_MISSES    = 3'd3
   } llc_reg_ofs_e;

   typedef struct packed {
      logic fire;
      logic write;
      logic hit;
   } llc_lookup_t;

   localparam int NUM_CTRS = 3;

endpackage

// File: rtl/llc_tag_store.sv
module llc_tag_store #(
   parameter int ADDR_W    = 32,
   parameter int CAP_LOG2  = 20,
   parameter int LINE_LOG2 = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              hit
);
   localparam int IDX_W = CAP_LOG2 - LINE_LOG2;
   localparam int SETS  = 1 << IDX_W;
   localparam int TAG_W = ADDR_W - CAP_LOG2;

   logic [SETS-1:0]  valid_q;
   logic [TAG_W-1:0] tag_q [SETS];
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   logic             unused_offset;

   assign idx           = req_addr[CAP_LOG2-1:LINE_LOG2];
   assign tag           = req_addr[ADDR_W-1:CAP_LOG2];
   assign unused_offset = ^req_addr[LINE_LOG2-1:0];
   assign hit           = valid_q[idx] && (tag_q[idx] == tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (req_valid) begin
         valid_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (req_valid) begin
         tag_q[idx] <= tag;
      end
   end

   // R2
   install_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> valid_q[$past(idx)] && (tag_q[$past(idx)] == $past(tag)));

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (valid_q == '0));

endmodule

// File: rtl/llc_stall_gen.sv
module llc_stall_gen #(
   parameter int STALL_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [STALL_W-1:0] stall_len,
   output logic               stall_req
);
   logic [STALL_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= stall_len;
      end else if (remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign stall_req = (remain_q != '0);

   // R3
   countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_req && !load) |=> (remain_q == $past(remain_q) - 1'b1));

   // R10
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && stall_len != '0) |=> stall_req);

endmodule

// File: rtl/llc_sat_ctr.sv
module llc_sat_ctr #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] value
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != TOP)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign value = cnt_q;

   // R8
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == TOP) |=> (cnt_q == TOP));

   // R7
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/llc_stat_regs.sv
module llc_stat_regs
   import llc_emu_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int STALL_W    = 8,
   parameter int STALL_INIT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  llc_lookup_t        lkp,
   input  logic               reg_wr,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [REG_DW-1:0]  reg_wdata,
   output logic [REG_DW-1:0]  reg_rdata,
   output logic [STALL_W-1:0] stall_len
);
   logic [STALL_W-1:0]  len_q;
   logic [NUM_CTRS-1:0] bump;
   logic [CNT_W-1:0]    ctr_val [NUM_CTRS];
   logic                unused_wdata;

   assign unused_wdata = ^reg_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= STALL_W'(STALL_INIT);
      end else if (reg_wr && (reg_addr == OFS_STALL_LEN)) begin
         len_q <= reg_wdata[STALL_W-1:0];
      end
   end

   assign stall_len = len_q;

   assign bump[0] = lkp.fire;
   assign bump[1] = lkp.fire && lkp.hit;
   assign bump[2] = lkp.fire && !lkp.hit;

   for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
      llc_sat_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (bump[g]),
         .value (ctr_val[g])
      );
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_STALL_LEN: reg_rdata[STALL_W-1:0] = len_q;
         OFS_ACCESSES:  reg_rdata[CNT_W-1:0]   = ctr_val[0];
         OFS_HITS:      reg_rdata[CNT_W-1:0]   = ctr_val[1];
         OFS_MISSES:    reg_rdata[CNT_W-1:0]   = ctr_val[2];
         default:       reg_rdata = '0;
      endcase
   end

   // R9
   len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_addr == OFS_STALL_LEN) |=> $stable(len_q));

endmodule

// File: rtl/llc_tag_emu.sv
module llc_tag_emu
   import llc_emu_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CAP_LOG2   = 20,
   parameter int LINE_LOG2  = 9,
   parameter int CNT_W      = 32,
   parameter int STALL_W    = 8,
   parameter int STALL_INIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_valid,
   input  logic              snp_write,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              stall_req,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   if (CAP_LOG2 < 20 || CAP_LOG2 > 26) begin : g_bad_cap
      $error("CAP_LOG2 must lie in 20..26");
   end
   if (LINE_LOG2 < 5 || LINE_LOG2 > 9) begin : g_bad_line
      $error("LINE_LOG2 must lie in 5..9");
   end
   if (ADDR_W <= CAP_LOG2) begin : g_bad_addr
      $error("ADDR_W must exceed CAP_LOG2");
   end
   if (CNT_W < 1 || CNT_W > REG_DW || STALL_W < 1 || STALL_W > REG_DW) begin : g_bad_w
      $error("counter and stall widths must lie in 1..32");
   end

   llc_lookup_t        lkp;
   logic               tag_hit;
   logic [STALL_W-1:0] stall_len;
   logic               rd_miss;

   llc_tag_store #(
      .ADDR_W    (ADDR_W),
      .CAP_LOG2  (CAP_LOG2),
      .LINE_LOG2 (LINE_LOG2)
   ) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (snp_valid),
      .req_addr  (snp_addr),
      .hit       (tag_hit)
   );

   assign lkp.fire  = snp_valid;
   assign lkp.write = snp_write;
   assign lkp.hit   = tag_hit;
   assign rd_miss   = lkp.fire && !lkp.write && !lkp.hit;

   llc_stall_gen #(.STALL_W(STALL_W)) u_stall (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (rd_miss),
      .stall_len (stall_len),
      .stall_req (stall_req)
   );

   llc_stat_regs #(
      .CNT_W      (CNT_W),
      .STALL_W    (STALL_W),
      .STALL_INIT (STALL_INIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .lkp       (lkp),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .stall_len (stall_len)
   );

   // R3
   miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !snp_write && !tag_hit && stall_len != '0) |=> stall_req);

   // R4
   hit_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !snp_write && tag_hit && !stall_req) |=> !stall_req);

   // R5
   write_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_write && !stall_req) |=> !stall_req);

   // R6
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_len == '0 && !stall_req) |=> !stall_req);

endmodule

// File: tb/llc_tag_emu_test.sv
`timescale 1ns/1ps
module llc_tag_emu_test;
   localparam int CW   = 10;
   localparam int CMAX = (1 << CW) - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        snp_valid = 1'b0;
   logic        snp_write = 1'b0;
   logic [31:0] snp_addr = '0;
   logic        stall_req;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int total = 0;
   int bad = 0;

   bit        m_valid [2048];
   bit [11:0] m_tag [2048];
   int        m_len = 4;
   int        m_acc = 0;
   int        m_hit = 0;
   int        m_miss = 0;

   always #2 clk = ~clk;

   llc_tag_emu #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_write(snp_write),
      .snp_addr(snp_addr), .stall_req(stall_req), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic int sat_inc(input int v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   function automatic logic [31:0] mk_addr(input int tg, input int ix, input int ofs);
      return {tg[11:0], ix[10:0], ofs[8:0]};
   endfunction

   // returns expected stall length and updates the model
   function automatic int model_txn(input logic [31:0] a, input bit wr);
      int  ix = int'(a[19:9]);
      bit  h  = m_valid[ix] && (m_tag[ix] == a[31:20]);
      m_valid[ix] = 1'b1;
      m_tag[ix]   = a[31:20];
      m_acc = sat_inc(m_acc);
      if (h) m_hit = sat_inc(m_hit);
      else   m_miss = sat_inc(m_miss);
      return (!wr && !h) ? m_len : 0;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output int d);
      @(negedge clk);
      reg_addr = a;
      #0.5;
      d = int'(reg_rdata);
   endtask

   task automatic wr_reg(input logic [2:0] a, input int d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 3'd0) m_len = d & 8'hFF;
   endtask

   task automatic txn(input string req, input logic [31:0] a, input bit wr);
      int exp, cnt;
      exp = model_txn(a, wr);
      @(negedge clk);
      snp_valid = 1'b1; snp_write = wr; snp_addr = a;
      @(negedge clk);
      snp_valid = 1'b0;
      cnt = 0;
      while (stall_req && cnt < 400) begin
         cnt++;
         @(negedge clk);
      end
      check(req, cnt, exp);
   endtask

   task automatic check_ctrs(input string req);
      int v;
      rd(3'd1, v); check({req, " accesses"}, v, m_acc);
      rd(3'd2, v); check({req, " hits"}, v, m_hit);
      rd(3'd3, v); check({req, " misses"}, v, m_miss);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int v, h;
      void'($urandom(32'd4711));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 stall_req", int'(stall_req), 0);
      rd(3'd0, v); check("R1 stall length", v, 4);
      check_ctrs("R1");
      txn("R1 cold miss stalls", mk_addr(0, 0, 0), 1'b0);

      // R4 same line other offset hits
      txn("R3 miss", mk_addr(1, 5, 3), 1'b0);
      txn("R4 same line hit", mk_addr(1, 5, 200), 1'b0);
      // R2 conflict eviction in one set, neighbour set independent
      txn("R2 other set miss", mk_addr(1, 6, 0), 1'b0);
      txn("R2 same set new tag", mk_addr(2, 5, 0), 1'b0);
      txn("R2 evicted tag misses", mk_addr(1, 5, 0), 1'b0);
      txn("R2 neighbour still hits", mk_addr(1, 6, 8), 1'b0);
      // R5 write allocate without stall
      txn("R5 write miss no stall", mk_addr(7, 9, 0), 1'b1);
      txn("R5 read after write hits", mk_addr(7, 9, 4), 1'b0);
      txn("R5 write hit no stall", mk_addr(7, 9, 4), 1'b1);
      check_ctrs("R7");

      // R9 register map
      wr_reg(3'd0, 7);
      rd(3'd0, v); check("R9 stall length readback", v, 7);
      wr_reg(3'd2, 99);
      wr_reg(3'd5, 55);
      rd(3'd5, v); check("R9 unmapped reads zero", v, 0);
      rd(3'd0, v); check("R9 stall length unchanged", v, 7);
      check_ctrs("R9 ro counters");
      txn("R3 miss with length 7", mk_addr(3, 40, 0), 1'b0);

      // R6 zero length
      wr_reg(3'd0, 0);
      txn("R6 miss without stall", mk_addr(3, 41, 0), 1'b0);
      txn("R6 hit", mk_addr(3, 41, 1), 1'b0);
      check_ctrs("R6");

      // R10 restart during stall
      wr_reg(3'd0, 6);
      void'(model_txn(mk_addr(9, 100, 0), 1'b0));
      void'(model_txn(mk_addr(9, 101, 0), 1'b0));
      @(negedge clk);
      snp_valid = 1'b1; snp_write = 1'b0; snp_addr = mk_addr(9, 100, 0);
      @(negedge clk);
      snp_valid = 1'b0; h = int'(stall_req);
      @(negedge clk);
      h += int'(stall_req);
      snp_valid = 1'b1; snp_addr = mk_addr(9, 101, 0);
      @(negedge clk);
      snp_valid = 1'b0;
      while (stall_req && h < 400) begin
         h++;
         @(negedge clk);
      end
      check("R10 restarted stall total", h, 8);

      // random mix over a few sets and tags
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a;
         if ($urandom_range(0, 19) == 0) wr_reg(3'd0, $urandom_range(0, 5));
         if ($urandom_range(0, 9) == 0)
            a = $urandom;
         else
            a = mk_addr($urandom_range(0, 3), $urandom_range(0, 7), $urandom_range(0, 511));
         txn("R3 R4 R5 random", a, 1'($urandom_range(0, 3) == 0));
         if (i % 60 == 59) check_ctrs("R7 random");
      end

      // R8 saturation burst
      wr_reg(3'd0, 0);
      for (int i = 0; i < 1100; i++) begin
         logic [31:0] a;
         bit w;
         a = mk_addr($urandom_range(0, 3), $urandom_range(0, 3), 0);
         w = 1'($urandom_range(0, 1));
         void'(model_txn(a, w));
         @(negedge clk);
         snp_valid = 1'b1; snp_write = w; snp_addr = a;
      end
      @(negedge clk);
      snp_valid = 1'b0;
      check("R8 no stall in burst", int'(stall_req), 0);
      rd(3'd1, v); check("R8 accesses saturated", v, CMAX);
      check_ctrs("R8");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule